// File: doc/BRIEF.md
# Energy Pulse Output Shaper

This block turns a stream of single-cycle energy-quantum strobes into an active-low metering pulse line. Each strobe stands for one energy quantum that an upstream accumulator has already detected. A programmable divisor sets how many strobes make one output period. Every period opens with a falling edge of the output and a one-cycle event flag.

The shape of the low phase depends on how fast the output runs. The block measures each period in clocks. After a long period (slow output), the pulse is low for a fixed 80 ms. After a short period (fast output), the low phase follows the strobe count. With an even divisor this gives an exact 50% duty cycle. With an odd divisor the low phase is one strobe longer than the high phase. All time constants come from the clock frequency parameter. The default of 16.384 MHz gives an 80 ms width of 1,310,720 clocks and a 160 ms slow threshold of 2,621,440 clocks.

Top module: `efp_pulse_top`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `enable` is seen low, `pulse_n` is 1 and `pulse_evt` is 0. The strobe position and the period timer are cleared, so the next strobe opens a new period that uses the fixed-width shape.
- R2: An output period holds exactly N strobes, where N is the effective divisor. The strobe that opens a period is the first one after reset or enable, and every N-th strobe after it. Only these opening strobes raise `pulse_evt`.
- R3: A `cf_den` of 0 behaves as a divisor of 1. Every strobe opens a period.
- R4: When an opening strobe is sampled on a clock edge, `pulse_n` is 0 and `pulse_evt` is 1 after that same edge. `pulse_evt` lasts one cycle for each opening strobe.
- R5: In count-based shape with an even N > 1, `pulse_n` rises on the strobe at position N/2 of the period (positions count from 0). The output is low for N/2 strobes and high for N/2 strobes.
- R6: In count-based shape with an odd N > 1, `pulse_n` rises on the strobe at position (N+1)/2. The output is low for (N+1)/2 strobes and high for (N-1)/2 strobes.
- R7: The shape is chosen when each period opens. Fixed-width shape is used if the previous period lasted more than 2×80 ms worth of clocks, if the period is the first one since reset or enable, or if N is 1. Otherwise count-based shape is used.
- R8: A fixed-width pulse stays low for exactly 80 ms worth of clocks (CLK_HZ×80/1000). Strobes at the half point have no effect on it.
- R9: An opening strobe that arrives while a fixed-width pulse is still low does not lengthen that pulse. It still raises `pulse_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low forces the idle state |
| energy_strobe | input | 1 | One-cycle energy quantum strobe |
| cf_den | input | DEN_W | Strobes per output period (0 acts as 1) |
| pulse_n | output | 1 | Active-low metering pulse |
| pulse_evt | output | 1 | One-cycle flag at the start of each period |

## Verification
The assertions assume that `energy_strobe` is a single-cycle pulse. They also assume that `cf_den` only changes while the block is disabled or between periods. The strobe-position range check is excused in the cycle after the divisor changes. The stimulus changes the divisor only while `enable` is low, and it always returns the strobe line to 0 for at least one cycle. Time constants are scaled down through `CLK_HZ` so that fixed-width pulses and slow periods fit in a short run. The ratio between the 80 ms width and the 160 ms threshold is kept.

// File: rtl/efp_pkg.sv
package efp_pkg;

  typedef enum logic {
    SHAPE_FIXED = 1'b0,
    SHAPE_DUTY  = 1'b1
  } shape_e;

  // divisor of zero is treated as one
  function automatic int unsigned eff_div(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // number of strobes the output stays low in count-based shape
  function automatic int unsigned low_strobes(input int unsigned n);
    return (n + 1) / 2;
  endfunction

  // clocks for a time span given in milliseconds
  function automatic int unsigned ms_to_clks(input int unsigned hz, input int unsigned ms);
    return int'((longint'(hz) * longint'(ms)) / 1000);
  endfunction

endpackage

// File: rtl/efp_strobe_div.sv
module efp_strobe_div
  import efp_pkg::*;
#(
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             strobe_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             start_o,
  output logic             half_o,
  output logic             unit_o
);

  logic [DEN_W-1:0] den_eff;
  logic [DEN_W-1:0] low_n;
  logic [DEN_W-1:0] pos_q;

  always_comb begin
    den_eff = DEN_W'(eff_div(32'(den_i)));
    low_n   = DEN_W'(low_strobes(32'(den_eff)));
    unit_o  = (den_eff == DEN_W'(1));
    start_o = en && strobe_i && (pos_q == '0);
    half_o  = en && strobe_i && !unit_o && (pos_q == low_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (!en) begin
      pos_q <= '0;
    end else if (strobe_i) begin
      if (pos_q >= den_eff - DEN_W'(1)) pos_q <= '0;
      else                              pos_q <= pos_q + DEN_W'(1);
    end
  end

  // strobe position stays inside the period while the divisor is steady
  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n || !en)
    ($stable(den_i) && ($past(pos_q) < $past(den_eff))) |-> (pos_q < den_eff));

endmodule

// File: rtl/efp_period_meter.sv
module efp_period_meter #(
  parameter int unsigned SLOW_CLKS = 2621440
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_i,
  output logic long_o
);

  localparam int unsigned LIM = SLOW_CLKS + 1;
  localparam int          TW  = $clog2(LIM + 1);

  logic [TW-1:0] elapsed_q;

  // elapsed_q holds the clocks since the last opening strobe, saturating at LIM
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed_q <= TW'(LIM);
    end else if (!en) begin
      elapsed_q <= TW'(LIM);
    end else if (start_i) begin
      elapsed_q <= TW'(1);
    end else if (elapsed_q < TW'(LIM)) begin
      elapsed_q <= elapsed_q + TW'(1);
    end
  end

  assign long_o = (elapsed_q > TW'(SLOW_CLKS));

  assert_meter_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed_q <= TW'(LIM));

  assert_meter_restart_R7: assert property (@(posedge clk) disable iff (!rst_n || !en)
    start_i |=> !long_o);

endmodule

// File: rtl/efp_pulse_shaper.sv
module efp_pulse_shaper
  import efp_pkg::*;
#(
  parameter int unsigned FIXED_CLKS = 1310720
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_i,
  input  logic half_i,
  input  logic fixed_i,
  output logic low_o,
  output logic event_o
);

  localparam int FW = $clog2(FIXED_CLKS + 1);
  localparam logic [FW-1:0] LAST = FW'(FIXED_CLKS - 1);

  logic          low_q;
  logic          evt_q;
  shape_e        shape_q;
  logic [FW-1:0] fix_cnt_q;
  logic          keep_run;

  // an opening strobe during a fixed pulse lets the running width continue
  assign keep_run = fixed_i && low_q && (shape_q == SHAPE_FIXED) && (fix_cnt_q != LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      low_q     <= 1'b0;
      evt_q     <= 1'b0;
      shape_q   <= SHAPE_FIXED;
      fix_cnt_q <= '0;
    end else begin
      evt_q <= start_i;
      if (start_i) begin
        low_q     <= 1'b1;
        shape_q   <= fixed_i ? SHAPE_FIXED : SHAPE_DUTY;
        fix_cnt_q <= keep_run ? fix_cnt_q + FW'(1) : '0;
      end else if (low_q) begin
        if (shape_q == SHAPE_FIXED) begin
          if (fix_cnt_q == LAST) begin
            low_q     <= 1'b0;
            fix_cnt_q <= '0;
          end else begin
            fix_cnt_q <= fix_cnt_q + FW'(1);
          end
        end else if (half_i) begin
          low_q <= 1'b0;
        end
      end
    end
  end

  assign low_o   = low_q;
  assign event_o = evt_q;

  assert_duty_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (low_q && (shape_q == SHAPE_DUTY) && !half_i && !start_i) |=> low_q);

  assert_duty_release_R6: assert property (@(posedge clk) disable iff (!rst_n || !en)
    ($fell(low_q) && $past(en) && ($past(shape_q) == SHAPE_DUTY)) |-> $past(half_i));

  assert_fixed_span_R8: assert property (@(posedge clk) disable iff (!rst_n || !en)
    ($fell(low_q) && $past(en) && ($past(shape_q) == SHAPE_FIXED)) |-> ($past(fix_cnt_q) == LAST));

endmodule

// File: rtl/efp_pulse_top.sv
module efp_pulse_top
  import efp_pkg::*;
#(
  parameter int          DEN_W    = 16,
  parameter int unsigned CLK_HZ   = 16384000,
  parameter int unsigned PULSE_MS = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             energy_strobe,
  input  logic [DEN_W-1:0] cf_den,
  output logic             pulse_n,
  output logic             pulse_evt
);

  localparam int unsigned FIXED_CLKS = ms_to_clks(CLK_HZ, PULSE_MS);
  localparam int unsigned SLOW_CLKS  = 2 * FIXED_CLKS;

  logic period_start;
  logic half_point;
  logic unit_div;
  logic long_gap;
  logic use_fixed;
  logic low_level;

  efp_strobe_div #(.DEN_W(DEN_W)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .strobe_i (energy_strobe),
    .den_i    (cf_den),
    .start_o  (period_start),
    .half_o   (half_point),
    .unit_o   (unit_div)
  );

  efp_period_meter #(.SLOW_CLKS(SLOW_CLKS)) meter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .start_i (period_start),
    .long_o  (long_gap)
  );

  assign use_fixed = long_gap || unit_div;

  efp_pulse_shaper #(.FIXED_CLKS(FIXED_CLKS)) shaper_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .start_i (period_start),
    .half_i  (half_point),
    .fixed_i (use_fixed),
    .low_o   (low_level),
    .event_o (pulse_evt)
  );

  assign pulse_n = ~low_level;

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && period_start) |=> (!pulse_n && pulse_evt));

  assert_evt_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt |-> !pulse_n);

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pulse_n && !pulse_evt));

endmodule

// File: tb/efp_pulse_top_tb_top.sv
module efp_pulse_top_tb_top;

  localparam int DEN_W  = 16;
  localparam int CLK_HZ = 5000;          // scaled: 80 ms -> 400 clocks
  localparam int FIXW   = CLK_HZ * 80 / 1000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             energy_strobe = 1'b0;
  logic [DEN_W-1:0] cf_den = '0;
  logic             pulse_n;
  logic             pulse_evt;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  efp_pulse_top #(.DEN_W(DEN_W), .CLK_HZ(CLK_HZ), .PULSE_MS(80)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .energy_strobe (energy_strobe),
    .cf_den        (cf_den),
    .pulse_n       (pulse_n),
    .pulse_evt     (pulse_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one strobe; returns with outputs sampled after the edge that saw it
  task automatic send_strobe();
    @(negedge clk) energy_strobe = 1'b1;
    @(negedge clk) energy_strobe = 1'b0;
  endtask

  task automatic restart(input int den);
    @(negedge clk) enable = 1'b0;
    cf_den = DEN_W'(den);
    idle(2);
    enable = 1'b1;
  endtask

  task automatic t_reset();
    idle(3);
    chk(pulse_n == 1'b1, "R1 reset pulse_n", int'(pulse_n), 1);
    chk(pulse_evt == 1'b0, "R1 reset evt", int'(pulse_evt), 0);
    rst_n = 1'b1;
    idle(2);
  endtask

  // fast strobes, count-based shape checked strobe by strobe (R2 R5 R6)
  task automatic t_duty(input int den, input string req);
    int lown;
    lown = (den + 1) / 2;
    restart(den);
    for (int k = 0; k < den * 6; k++) begin
      send_strobe();
      if (k >= den) begin
        chk(pulse_evt == ((k % den) == 0), {req, " R2 evt"}, int'(pulse_evt), int'((k % den) == 0));
        chk(pulse_n == !((k % den) < lown), {req, " level"}, int'(pulse_n), int'(!((k % den) < lown)));
      end
      idle(10);
    end
  endtask

  // first period after enable is fixed; half-point strobe ignored (R7 R8)
  task automatic t_first_fixed();
    restart(2);
    send_strobe();
    chk(pulse_evt == 1'b1, "R4 evt on start", int'(pulse_evt), 1);
    idle(10);
    send_strobe();
    chk(pulse_n == 1'b0, "R7 first period fixed", int'(pulse_n), 0);
  endtask

  // slow strobes: fixed 80 ms width measured in clocks (R7 R8)
  task automatic t_slow();
    int lows;
    restart(2);
    for (int p = 0; p < 2; p++) begin
      send_strobe();
      chk(pulse_evt == 1'b1 && pulse_n == 1'b0, "R4 slow start", int'(pulse_n), 0);
      lows = 1;
      for (int j = 0; j < 999; j++) begin
        @(negedge clk);
        if (!pulse_n) lows++;
      end
      chk(lows == FIXW, "R8 fixed width", lows, FIXW);
      send_strobe();
      chk(pulse_n == 1'b1 && pulse_evt == 1'b0, "R8 half strobe ignored", int'(pulse_n), 1);
      idle(1000);
    end
  endtask

  // restart inside a fixed pulse does not extend it (R9)
  task automatic t_no_extend();
    int lows;
    int evts;
    restart(1);
    send_strobe();
    lows = 1;
    evts = 0;
    for (int j = 0; j < 449; j++) begin
      @(negedge clk);
      energy_strobe = (j == 150 || j == 300);
      if (!pulse_n) lows++;
      if (pulse_evt) evts++;
    end
    energy_strobe = 1'b0;
    chk(lows == FIXW, "R9 width not extended", lows, FIXW);
    chk(evts == 2, "R9 events still raised", evts, 2);
    idle(5);
  endtask

  // divisor zero acts as one (R3)
  task automatic t_zero_den();
    restart(0);
    for (int k = 0; k < 3; k++) begin
      send_strobe();
      chk(pulse_evt == 1'b1, "R3 every strobe opens", int'(pulse_evt), 1);
      idle(500);
      chk(pulse_n == 1'b1, "R3 pulse ended", int'(pulse_n), 1);
    end
  endtask

  // disable mid-pulse forces idle and clears position (R1)
  task automatic t_enable();
    restart(3);
    send_strobe();
    idle(5);
    send_strobe();
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(pulse_n == 1'b1, "R1 disable releases", int'(pulse_n), 1);
    chk(pulse_evt == 1'b0, "R1 disable evt", int'(pulse_evt), 0);
    enable = 1'b1;
    idle(2);
    send_strobe();
    chk(pulse_evt == 1'b1, "R1 position cleared", int'(pulse_evt), 1);
    idle(5);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_fixed();
        t_duty(4, "R5 den4");
        t_duty(2, "R5 den2");
        t_duty(3, "R6 den3");
        t_duty(5, "R6 den5");
        t_slow();
        t_no_extend();
        t_zero_den();
        t_enable();
      end
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule